// File: doc/BRIEF.md
# Two-Plane Blinking Segment Display Controller

This block drives a multiplexed common-cathode segment display of up to eight digits. A host loads it through a write-only SPI link. Each digit keeps two bytes of segment data, called plane 0 and plane 1. When blinking is enabled, a timer switches the shown plane at a fixed rate, so every segment whose bit differs between the planes flashes with no further host traffic. The host can write plane 0 alone, plane 1 alone, or both planes with one frame. Which of these happens depends on the upper three address bits of the frame.

The host also loads five control registers: per-digit hex decoding, a 16-step brightness level, the number of digits scanned, a configuration byte and a lamp-test switch. The scanner gives each digit a fixed slot of `SLOT_CYCLES` clocks, which is 200 µs at a 4 MHz timebase. It drives a one-hot digit-enable vector and the segment byte of the shown plane, and it reports the shown plane on `blink_phase`.

Two state machines do the work. The receiver has the states RX_IDLE, RX_SHIFT and RX_COMMIT:
- RX_IDLE goes to RX_SHIFT when chip-select falls.
- RX_SHIFT goes to RX_COMMIT when chip-select rises after exactly 16 bits.
- RX_SHIFT goes back to RX_IDLE when chip-select rises after any other bit count.
- RX_COMMIT goes back to RX_IDLE after one cycle, or to RX_SHIFT if chip-select has already fallen again.

The scanner has the states SC_DARK and SC_SCAN:
- SC_DARK goes to SC_SCAN when the run bit or the lamp test is set.
- SC_SCAN goes back to SC_DARK when both are clear.

Top module: `blink_disp_ctrl`

## Requirements
- R1: A frame is 16 bits sampled MSB first on SCLK rising edges while CS_N is low. Bits 15..8 are the address and bits 7..0 are the data. The frame takes effect when CS_N rises. A frame with any other bit count is discarded.
- R2: Addresses 0x20+d (d = 0..7) write digit d of plane 0 and leave plane 1 unchanged.
- R3: Addresses 0x40+d write digit d of plane 1 and leave plane 0 unchanged.
- R4: Addresses 0x60+d write the same byte into both planes of digit d.
- R5: Frames to any address outside the control registers (0x01, 0x02, 0x03, 0x04, 0x07) and the digit ranges change no state. This includes 0x00, 0x05, 0x30, 0x48 and 0x80.
- R6: Configuration register 0x04 has three bits: bit 0 is run, bit 2 selects the fast blink rate and bit 3 enables blinking. While blinking is disabled, `blink_phase` is 0 and plane 0 is shown.
- R7: While blinking is enabled, `blink_phase` toggles every FAST_SLOTS slots (fast rate) or every SLOW_SLOTS slots (slow rate), and toggles only at a slot boundary. The shown segments come from plane `blink_phase`.
- R8: Scan limit register 0x03 = n makes the controller visit digits 0..n in ascending order, each for SLOT_CYCLES clocks. `dig_en` bit d is high only while digit d is shown, and at most one bit is ever high.
- R9: Intensity register 0x02 = k (low 4 bits) lights the segments for k*SLOT_CYCLES/16 clocks at the start of each slot. k = 0 keeps them dark.
- R10: Decode register 0x01 bit d set makes digit d show the hex glyph of its low nibble, with bit 7 (decimal point) passed through. The segment encoding is `seg[7]`=dp, `seg[6]`=a through `seg[0]`=g; for example 0xA maps to 0x77 and 0x3 maps to 0x79. When the bit is clear, the raw byte is shown.
- R11: Lamp-test register 0x07 bit 0 set forces `seg` = 0xFF for the whole of every slot, whatever the run bit and intensity are.
- R12: With run and lamp test both clear, `dig_en` and `seg` are 0. After reset every register is 0, so the display is dark and `blink_phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Multiplex timebase clock (1–8 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| dig_en | output | NUM_DIGITS | One-hot digit enable, active high |
| seg | output | 8 | Segment drive {dp,a,b,c,d,e,f,g}, active high |
| blink_phase | output | 1 | Plane currently shown |

## Verification
A digit write can land in the same cycle in which the blink timer flips the shown plane. The two then meet in the plane multiplexer feeding the segment register. With fast blinking running, the bench writes a new byte to plane 1 of one digit eight times in a row. Each frame ends at a different offset within the blink period, so some commits land on or next to a flip. After each write the bench judges the next plane-1 slot, which must show the new byte, and the next plane-0 slot, which must still show the old byte. The bench also measures exact toggle intervals after changing the rate.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

    localparam int MAX_DIGITS = 8;
    localparam int FRAME_W    = 16;
    localparam int BYTE_W     = 8;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_COMMIT
    } rx_state_t;

    typedef enum logic {
        SC_DARK,
        SC_SCAN
    } scan_state_t;

    localparam logic [7:0] ADR_DECODE = 8'h01;
    localparam logic [7:0] ADR_BRIGHT = 8'h02;
    localparam logic [7:0] ADR_LIMIT  = 8'h03;
    localparam logic [7:0] ADR_CONFIG = 8'h04;
    localparam logic [7:0] ADR_LAMP   = 8'h07;

    // address bits [7:5] select the plane group of a digit write
    localparam logic [2:0] GRP_P0   = 3'b001;
    localparam logic [2:0] GRP_P1   = 3'b010;
    localparam logic [2:0] GRP_BOTH = 3'b011;

    localparam int CFG_RUN   = 0;
    localparam int CFG_FAST  = 2;
    localparam int CFG_BLINK = 3;

    typedef struct packed {
        logic [MAX_DIGITS-1:0] decode;
        logic [3:0]            bright;
        logic [2:0]            limit;
        logic                  run;
        logic                  fast;
        logic                  blink;
        logic                  lamp;
    } ctrl_t;

    function automatic logic [6:0] hex_glyph(input logic [3:0] v);
        logic [6:0] g;
        unique case (v)
            4'h0: g = 7'h7E;
            4'h1: g = 7'h30;
            4'h2: g = 7'h6D;
            4'h3: g = 7'h79;
            4'h4: g = 7'h33;
            4'h5: g = 7'h5B;
            4'h6: g = 7'h5F;
            4'h7: g = 7'h70;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h7B;
            4'hA: g = 7'h77;
            4'hB: g = 7'h1F;
            4'hC: g = 7'h4E;
            4'hD: g = 7'h3D;
            4'hE: g = 7'h4F;
            default: g = 7'h47;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/bdc_spi_rx.sv
module bdc_spi_rx
    import bdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       wr_valid,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);

    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}};

    logic [2:0] sclk_s;
    logic [2:0] cs_s;
    logic [1:0] mosi_s;
    logic       sclk_rise, cs_fall, cs_rise;

    rx_state_t           state, state_nx;
    logic [FRAME_W-1:0]  shreg;
    logic [CNT_W-1:0]    cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_s <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
        end else begin
            sclk_s <= {sclk_s[1:0], sclk};
            cs_s   <= {cs_s[1:0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    assign sclk_rise = sclk_s[1] & ~sclk_s[2];
    assign cs_fall   = ~cs_s[1] & cs_s[2];
    assign cs_rise   = cs_s[1] & ~cs_s[2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:   if (cs_fall) state_nx = RX_SHIFT;
            RX_SHIFT:  if (cs_rise) state_nx = (cnt == CNT_FULL) ? RX_COMMIT : RX_IDLE;
            RX_COMMIT: state_nx = cs_fall ? RX_SHIFT : RX_IDLE;
            default:   state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (state != RX_SHIFT && cs_fall) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (state == RX_SHIFT && sclk_rise) begin
            shreg <= {shreg[FRAME_W-2:0], mosi_s[1]};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        wr_valid = (state == RX_COMMIT);
        wr_addr  = shreg[FRAME_W-1 -: 8];
        wr_data  = shreg[7:0];
    end

    assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(cnt) == CNT_FULL);

endmodule

// File: rtl/bdc_regs.sv
module bdc_regs
    import bdc_pkg::*;
#(
    parameter int NUM_DIGITS = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_valid,
    input  logic [7:0]                       wr_addr,
    input  logic [7:0]                       wr_data,
    output ctrl_t                            ctrl,
    output logic [NUM_DIGITS-1:0][BYTE_W-1:0] plane0,
    output logic [NUM_DIGITS-1:0][BYTE_W-1:0] plane1
);

    logic [2:0] grp;
    logic       digit_hit, wr_p0, wr_p1, ctrl_hit;

    assign grp       = wr_addr[7:5];
    assign digit_hit = int'(wr_addr[4:0]) < NUM_DIGITS;
    assign wr_p0     = wr_valid && digit_hit && (grp == GRP_P0 || grp == GRP_BOTH);
    assign wr_p1     = wr_valid && digit_hit && (grp == GRP_P1 || grp == GRP_BOTH);
    assign ctrl_hit  = wr_addr == ADR_DECODE || wr_addr == ADR_BRIGHT || wr_addr == ADR_LIMIT
                    || wr_addr == ADR_CONFIG || wr_addr == ADR_LAMP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_valid) begin
            unique case (wr_addr)
                ADR_DECODE: ctrl.decode <= wr_data;
                ADR_BRIGHT: ctrl.bright <= wr_data[3:0];
                ADR_LIMIT:  ctrl.limit  <= wr_data[2:0];
                ADR_CONFIG: begin
                    ctrl.run   <= wr_data[CFG_RUN];
                    ctrl.fast  <= wr_data[CFG_FAST];
                    ctrl.blink <= wr_data[CFG_BLINK];
                end
                ADR_LAMP:   ctrl.lamp   <= wr_data[0];
                default:    ;
            endcase
        end
    end

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        logic sel;
        assign sel = (wr_addr[4:0] == 5'(d));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                plane0[d] <= '0;
                plane1[d] <= '0;
            end else begin
                if (wr_p0 && sel) plane0[d] <= wr_data;
                if (wr_p1 && sel) plane1[d] <= wr_data;
            end
        end
    end

    assert_ignore_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !ctrl_hit && !wr_p0 && !wr_p1)
            |=> ($stable(ctrl) && $stable(plane0) && $stable(plane1)));

    assert_p0_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && grp == GRP_P0) |=> $stable(plane1));

    assert_p1_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && grp == GRP_P1) |=> $stable(plane0));

endmodule

// File: rtl/bdc_scan.sv
module bdc_scan
    import bdc_pkg::*;
#(
    parameter int NUM_DIGITS  = 8,
    parameter int SLOT_CYCLES = 800,
    parameter int FAST_SLOTS  = 1250,
    parameter int SLOW_SLOTS  = 2500
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  ctrl_t                             ctrl,
    input  logic [NUM_DIGITS-1:0][BYTE_W-1:0] plane0,
    input  logic [NUM_DIGITS-1:0][BYTE_W-1:0] plane1,
    output logic [NUM_DIGITS-1:0]             dig_en,
    output logic [BYTE_W-1:0]                 seg,
    output logic                              blink_phase
);

    localparam int DIG_W   = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
    localparam int SLOT_W  = $clog2(SLOT_CYCLES);
    localparam int STEP    = SLOT_CYCLES / 16;
    localparam int HALF_MX = (FAST_SLOTS > SLOW_SLOTS) ? FAST_SLOTS : SLOW_SLOTS;
    localparam int BLK_W   = $clog2(HALF_MX + 1);
    localparam int ON_W    = SLOT_W + 1;

    scan_state_t       state, state_nx;
    logic [SLOT_W-1:0] slot_cnt;
    logic              slot_end;
    logic [DIG_W-1:0]  digit, lim_eff;
    logic [BLK_W-1:0]  blk_cnt, half;
    logic              active;
    logic [ON_W-1:0]   on_len;
    logic              pwm_on;
    logic [BYTE_W-1:0] raw, shown;

    assign active   = ctrl.run || ctrl.lamp;
    assign slot_end = (slot_cnt == SLOT_W'(SLOT_CYCLES - 1));
    assign half     = ctrl.fast ? BLK_W'(FAST_SLOTS) : BLK_W'(SLOW_SLOTS);
    assign on_len   = ON_W'(int'(ctrl.bright) * STEP);
    assign pwm_on   = {1'b0, slot_cnt} < on_len;

    always_comb begin
        if (int'(ctrl.limit) > NUM_DIGITS - 1) lim_eff = DIG_W'(NUM_DIGITS - 1);
        else                                    lim_eff = DIG_W'(ctrl.limit);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SC_DARK;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SC_DARK: if (active)  state_nx = SC_SCAN;
            SC_SCAN: if (!active) state_nx = SC_DARK;
            default: state_nx = SC_DARK;
        endcase
    end

    // slot, digit and blink timers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_cnt    <= '0;
            digit       <= '0;
            blk_cnt     <= '0;
            blink_phase <= 1'b0;
        end else if (state != SC_SCAN) begin
            slot_cnt    <= '0;
            digit       <= '0;
            blk_cnt     <= '0;
            blink_phase <= 1'b0;
        end else begin
            slot_cnt <= slot_end ? '0 : slot_cnt + 1'b1;
            if (slot_end) digit <= (digit >= lim_eff) ? '0 : digit + 1'b1;
            if (!ctrl.blink) begin
                blk_cnt     <= '0;
                blink_phase <= 1'b0;
            end else if (slot_end) begin
                if (blk_cnt >= half - 1'b1) begin
                    blk_cnt     <= '0;
                    blink_phase <= ~blink_phase;
                end else begin
                    blk_cnt <= blk_cnt + 1'b1;
                end
            end
        end
    end

    always_comb begin
        raw   = blink_phase ? plane1[digit] : plane0[digit];
        shown = ctrl.decode[digit] ? {raw[7], hex_glyph(raw[3:0])} : raw;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dig_en <= '0;
            seg    <= '0;
        end else begin
            unique case (state)
                SC_SCAN: begin
                    dig_en <= NUM_DIGITS'(1) << digit;
                    if (ctrl.lamp)  seg <= '1;
                    else if (pwm_on) seg <= shown;
                    else            seg <= '0;
                end
                default: begin
                    dig_en <= '0;
                    seg    <= '0;
                end
            endcase
        end
    end

    assert_onehot_digit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_en));

    assert_plane0_when_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.blink |=> !blink_phase);

    assert_flip_at_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blink_phase) |-> $past(slot_end));

    assert_lamp_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.lamp && state == SC_SCAN) |=> seg == '1);

    assert_dark_outputs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && state == SC_DARK) |=> (dig_en == '0 && seg == '0));

endmodule

// File: rtl/blink_disp_ctrl.sv
module blink_disp_ctrl
    import bdc_pkg::*;
#(
    parameter int NUM_DIGITS  = 8,
    parameter int SLOT_CYCLES = 800,
    parameter int FAST_SLOTS  = 1250,
    parameter int SLOW_SLOTS  = 2500
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic [NUM_DIGITS-1:0] dig_en,
    output logic [7:0]            seg,
    output logic                  blink_phase
);

    logic                              wr_valid;
    logic [7:0]                        wr_addr, wr_data;
    ctrl_t                             ctrl;
    logic [NUM_DIGITS-1:0][BYTE_W-1:0] plane0, plane1;

    bdc_spi_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    bdc_regs #(.NUM_DIGITS(NUM_DIGITS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl     (ctrl),
        .plane0   (plane0),
        .plane1   (plane1)
    );

    bdc_scan #(
        .NUM_DIGITS  (NUM_DIGITS),
        .SLOT_CYCLES (SLOT_CYCLES),
        .FAST_SLOTS  (FAST_SLOTS),
        .SLOW_SLOTS  (SLOW_SLOTS)
    ) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl        (ctrl),
        .plane0      (plane0),
        .plane1      (plane1),
        .dig_en      (dig_en),
        .seg         (seg),
        .blink_phase (blink_phase)
    );

endmodule

// File: tb/blink_disp_ctrl_tb.sv
module blink_disp_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NDIG = 8;
    localparam int SLOT = 32;
    localparam int FAST = 4;
    localparam int SLOW = 8;
    localparam int HB   = 4;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [NDIG-1:0] dig_en;
    logic [7:0] seg;
    logic blink_phase;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blink_disp_ctrl #(
        .NUM_DIGITS(NDIG), .SLOT_CYCLES(SLOT), .FAST_SLOTS(FAST), .SLOW_SLOTS(SLOW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .dig_en(dig_en), .seg(seg), .blink_phase(blink_phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [31:0] word, input int nbits);
        @(negedge clk); cs_n = 1'b0; ticks(HB);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = word[i]; ticks(HB);
            sclk = 1'b1; ticks(HB);
            sclk = 1'b0;
        end
        ticks(HB); cs_n = 1'b1; ticks(2 * HB);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        spi_bits({16'h0, a, d}, 16);
    endtask

    // OR of seg over one slot of digit idx shown with plane ph
    task automatic get_seg(input logic ph, input int idx, output logic [7:0] v);
        logic [NDIG-1:0] prev;
        prev = dig_en;
        forever begin
            @(negedge clk);
            if (dig_en == (NDIG'(1) << idx) && prev != dig_en && blink_phase == ph) break;
            prev = dig_en;
        end
        v = seg;
        for (int i = 1; i < SLOT; i++) begin @(negedge clk); v |= seg; end
    endtask

    task automatic toggle_gap(output int n);
        logic p;
        p = blink_phase; n = 0;
        while (blink_phase == p) begin @(negedge clk); end
        p = blink_phase;
        while (blink_phase == p) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset;
        chk("R12 reset dig_en", int'(dig_en), 0);
        chk("R12 reset seg", int'(seg), 0);
        chk("R12 reset blink_phase", int'(blink_phase), 0);
    endtask

    task automatic t_frames;
        logic [7:0] v;
        wr(8'h03, 8'h01); wr(8'h02, 8'h0F); wr(8'h04, 8'h01);
        wr(8'h60, 8'h5A);
        get_seg(1'b0, 0, v); chk("R1 16-bit frame committed", int'(v), 'h5A);
        spi_bits({17'h0, 15'h60FF >> 1}, 15);
        spi_bits({15'h0, 8'h60, 8'hFF, 1'b1}, 17);
        get_seg(1'b0, 0, v); chk("R1 short/long frames dropped", int'(v), 'h5A);
    endtask

    task automatic t_planes;
        logic [7:0] v;
        wr(8'h21, 8'h11);
        get_seg(1'b0, 1, v); chk("R2 plane0 write shown", int'(v), 'h11);
        wr(8'h41, 8'h22);
        get_seg(1'b0, 1, v); chk("R3 plane0 kept on plane1 write", int'(v), 'h11);
        wr(8'h04, 8'h0D);
        get_seg(1'b1, 1, v); chk("R3 plane1 write shown", int'(v), 'h22);
        wr(8'h21, 8'h33);
        get_seg(1'b1, 1, v); chk("R2 plane1 kept on plane0 write", int'(v), 'h22);
        get_seg(1'b0, 1, v); chk("R2 plane0 updated", int'(v), 'h33);
        wr(8'h61, 8'h44);
        get_seg(1'b0, 1, v); chk("R4 both planes p0", int'(v), 'h44);
        get_seg(1'b1, 1, v); chk("R4 both planes p1", int'(v), 'h44);
    endtask

    task automatic t_ignore;
        logic [7:0] v;
        int n;
        wr(8'h00, 8'hFF); wr(8'h05, 8'hFF); wr(8'h30, 8'hFF);
        wr(8'h48, 8'hFF); wr(8'h80, 8'hFF);
        get_seg(1'b0, 1, v); chk("R5 digit1 p0 untouched", int'(v), 'h44);
        get_seg(1'b1, 0, v); chk("R5 digit0 p1 untouched", int'(v), 'h5A);
        toggle_gap(n); chk("R5 config untouched (fast blink)", n, FAST * SLOT);
    endtask

    task automatic t_blink_timing;
        int n;
        wr(8'h04, 8'h09);
        toggle_gap(n); toggle_gap(n); chk("R7 slow half period", n, SLOW * SLOT);
        wr(8'h04, 8'h0D);
        toggle_gap(n); toggle_gap(n); chk("R7 fast half period", n, FAST * SLOT);
        wr(8'h04, 8'h01);
        ticks(4);
        begin
            int seen = 0;
            for (int i = 0; i < 3 * FAST * SLOT; i++) begin
                @(negedge clk); if (blink_phase) seen++;
            end
            chk("R6 blink disabled phase stays 0", seen, 0);
        end
    endtask

    task automatic t_scan;
        logic [NDIG-1:0] cur;
        int len;
        wr(8'h03, 8'h02);
        ticks(4 * SLOT);
        while (dig_en != 1) @(negedge clk);
        while (dig_en == 1) @(negedge clk);
        while (dig_en != 1) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            cur = dig_en; len = 0;
            while (dig_en == cur) begin @(negedge clk); len++; end
            chk("R8 slot length", len, SLOT);
            chk("R8 next digit", int'(dig_en), (k == 2) ? 1 : (2 << k));
        end
        wr(8'h03, 8'h01);
    endtask

    task automatic t_bright;
        int on, k;
        logic [NDIG-1:0] prev;
        wr(8'h60, 8'hFF);
        for (int j = 0; j < 3; j++) begin
            k = (j == 0) ? 0 : (j == 1) ? 5 : 15;
            wr(8'h02, 8'(k));
            prev = dig_en;
            forever begin
                @(negedge clk);
                if (dig_en == 1 && prev != 1) break;
                prev = dig_en;
            end
            on = (seg != 0) ? 1 : 0;
            for (int i = 1; i < SLOT; i++) begin @(negedge clk); if (seg != 0) on++; end
            chk("R9 lit cycles per slot", on, k * (SLOT / 16));
        end
    endtask

    task automatic t_decode;
        logic [7:0] v;
        wr(8'h01, 8'h01);
        wr(8'h60, 8'h8A); wr(8'h61, 8'h0A);
        get_seg(1'b0, 0, v); chk("R10 decoded A with dp", int'(v), 'hF7);
        get_seg(1'b0, 1, v); chk("R10 raw digit1", int'(v), 'h0A);
        wr(8'h60, 8'h03);
        get_seg(1'b0, 0, v); chk("R10 decoded 3", int'(v), 'h79);
        wr(8'h01, 8'h00);
    endtask

    task automatic t_lamp;
        int lit;
        wr(8'h04, 8'h00); wr(8'h02, 8'h00);
        ticks(4);
        chk("R12 run clear dark dig_en", int'(dig_en), 0);
        chk("R12 run clear dark seg", int'(seg), 0);
        wr(8'h07, 8'h01);
        ticks(4); lit = 0;
        for (int i = 0; i < 2 * SLOT; i++) begin
            @(negedge clk); if (seg == 8'hFF && dig_en != 0) lit++;
        end
        chk("R11 lamp test full on", lit, 2 * SLOT);
        wr(8'h07, 8'h00);
        ticks(4);
        chk("R12 dark after lamp test", int'(seg) | int'(dig_en), 0);
        wr(8'h02, 8'h0F);
    endtask

    // plane-1 write racing the blink flip
    task automatic t_race;
        logic [7:0] v;
        wr(8'h60, 8'h00);
        wr(8'h04, 8'h0D);
        for (int i = 0; i < 8; i++) begin
            ticks(i * 37);
            wr(8'h40, 8'(8'h10 + i));
            get_seg(1'b1, 0, v); chk("R3 racing write on plane1", int'(v), 8'h10 + i);
            get_seg(1'b0, 0, v); chk("R3 plane0 unaffected by race", int'(v), 0);
        end
    endtask

    initial begin
        ticks(5);
        t_reset();
        rst_n = 1'b1;
        ticks(5);
        t_frames();
        t_planes();
        t_ignore();
        t_blink_timing();
        t_scan();
        t_bright();
        t_decode();
        t_lamp();
        wr(8'h04, 8'h01);
        t_race();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule